// File: doc/BRIEF.md
# Receive Packet Buffer Manager

This block owns the on-chip packet memory used for incoming Ethernet frames. Memory is split into fixed pages of 128 sixteen-bit words, and every buffered frame is known by a small packet number. When a frame whose address already matched begins and reception is enabled, the block takes the lowest free packet number and the lowest free page. It then streams the payload words into memory at sequential logical word indices, starting at index 2. Each logical index is translated to a physical address made of a page number and a word offset. When the payload crosses a page boundary, another page is claimed without stalling the stream.

At the end of the frame, a good frame gets a status word written at logical index 0 and its byte count at index 1. Its packet number is then queued in a receive number FIFO. A non-empty FIFO raises the receive interrupt. A frame that ends with a bad CRC or an external overrun flag is released silently. A frame that runs out of pages is also released silently. The host reads the FIFO head and issues a single-cycle release strobe, which pops the head and returns its pages and number to the free pools.

The controller has five states. `ST_IDLE` waits for a frame start. `ST_RECV` writes payload. `ST_DROP` discards the rest of a frame that lost its memory. `ST_STAT` writes the status word. `ST_BCNT` writes the byte count and queues the number. The transitions are:
- `ST_IDLE`→`ST_RECV` on an accepted start.
- `ST_RECV`→`ST_DROP` on page exhaustion.
- `ST_RECV`→`ST_IDLE` on a rejected end.
- `ST_RECV`→`ST_STAT` on a good end.
- `ST_STAT`→`ST_BCNT` always.
- `ST_BCNT`→`ST_IDLE` always.
- `ST_DROP`→`ST_IDLE` on frame end.

Top module: `rx_pkt_buf_mgr`

## Requirements
- R1: After reset the FIFO is empty, `rxq_empty_o` is 1, `rx_int_o` is 0, `mem_we_o` is 0, and all 8 packet numbers and all 16 pages are free.
- R2: An accepted frame start takes the lowest free packet number and the lowest free page. Payload word k (from 0) is written combinationally in the cycle it is presented, at logical index k+2. The physical address is page*128 + (index mod 128).
- R3: When a payload word's logical index is a nonzero multiple of 128, the lowest free page is claimed for it in that same cycle. That page becomes the frame's next page.
- R4: On a good end (`frm_crc_ok_i`=1, `frm_ovr_i`=0), the cycle after the end pulse writes the status word to address first_page*128+0. The status word has bit 15 set and bits 4:0 holding the number of pages used. The next cycle writes 2*(payload words+2) to first_page*128+1. The packet number then enters the FIFO.
- R5: A frame ending with a bad CRC or the overrun flag writes no header, is not queued, leaves `rx_int_o` unchanged, and has its pages and number freed.
- R6: If a page is needed and none is free, that word is not written. The frame's pages and number are freed, and no write occurs until its end pulse.
- R7: A start that finds no free packet number or no free page is ignored, and none of that frame's words are written.
- R8: `rx_int_o` equals the inverse of `rxq_empty_o`, and `rxq_head_o` shows the oldest queued packet number.
- R9: A release strobe with a non-empty FIFO pops the head and frees its number and all its pages. With an empty FIFO the strobe has no effect.
- R10: While `rx_en_i` is 0 a frame start is ignored and no words are written.
- R11: Packet numbers leave the FIFO in the order their frames ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en_i | input | 1 | Receive enable |
| frm_start_i | input | 1 | Frame start pulse, address already matched |
| frm_vld_i | input | 1 | Payload word valid |
| frm_data_i | input | 16 | Payload word |
| frm_end_i | input | 1 | Frame end pulse |
| frm_crc_ok_i | input | 1 | CRC good, qualified by end |
| frm_ovr_i | input | 1 | External overrun, qualified by end |
| host_rel_i | input | 1 | Remove-and-release strobe |
| mem_we_o | output | 1 | Packet memory write enable |
| mem_addr_o | output | 11 | Physical word address {page, offset} |
| mem_wdata_o | output | 16 | Packet memory write data |
| rxq_head_o | output | 3 | Packet number at FIFO head |
| rxq_empty_o | output | 1 | FIFO empty |
| rx_int_o | output | 1 | Receive interrupt |

## Verification
The bench targets the page-boundary word at index 128. A design that allocates one word late would write it into the previous page. It also targets a 2000-word frame that fills all 16 pages, followed by a 2100-word frame that exhausts memory. Leaking pages on either drop path would make a later frame land on a page other than 0. The bench fills all eight packet numbers, so a ninth frame must be ignored instead of reusing a queued number. It also strobes release on an empty FIFO, which a careless design would turn into a pop that corrupts the pointers. Header words are checked against the page count and byte count to catch off-by-one counts.

// File: rtl/rxbm_pkg.sv
package rxbm_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RECV,
        ST_DROP,
        ST_STAT,
        ST_BCNT
    } rxbm_state_e;
endpackage

// File: rtl/rxbm_free_pool.sv
module rxbm_free_pool #(
    parameter int N = 16,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take_i,
    input  logic [N-1:0]  rel_mask_i,
    output logic          avail_o,
    output logic [IW-1:0] idx_o,
    output logic [N-1:0]  free_o
);
    logic [N-1:0] free_q;
    logic [N-1:0] take_mask;

    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (free_q[i]) idx_o = IW'(i);
        end
    end

    assign avail_o   = |free_q;
    assign free_o    = free_q;
    assign take_mask = take_i ? (N'(1) << idx_o) : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) free_q <= '1;
        else        free_q <= (free_q & ~take_mask) | rel_mask_i;
    end

    p_take_avail_r2: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |-> avail_o);
    p_rel_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_mask_i & free_q) == '0);
endmodule

// File: rtl/rxbm_num_fifo.sv
module rxbm_num_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 3,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic [W-1:0] data_i,
    input  logic         pop_i,
    output logic [W-1:0] head_o,
    output logic         empty_o
);
    logic [W-1:0]  slot_q [DEPTH];
    logic [PW-1:0] rd_q, wr_q;
    logic [CW-1:0] cnt_q;

    assign head_o  = slot_q[rd_q];
    assign empty_o = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
        end else begin
            if (push_i) begin
                slot_q[wr_q] <= data_i;
                wr_q <= (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
            end
            if (pop_i) rd_q <= (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
            cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
        end
    end

    p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> (cnt_q != CW'(DEPTH)));
    p_pop_nonempty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> !empty_o);
    p_last_pop_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && cnt_q == CW'(1)) |=> empty_o);
endmodule

// File: rtl/rx_pkt_buf_mgr.sv
module rx_pkt_buf_mgr #(
    parameter int NUM_PKT    = 8,
    parameter int NUM_PAGE   = 16,
    parameter int PAGE_WORDS = 128,
    parameter int WORD_W     = 16,
    localparam int PKT_W  = $clog2(NUM_PKT),
    localparam int PG_W   = $clog2(NUM_PAGE),
    localparam int OFF_W  = $clog2(PAGE_WORDS),
    localparam int ADDR_W = PG_W + OFF_W,
    localparam int IDX_W  = $clog2(NUM_PAGE * PAGE_WORDS) + 1,
    localparam int CNT_W  = $clog2(NUM_PAGE) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en_i,
    input  logic              frm_start_i,
    input  logic              frm_vld_i,
    input  logic [WORD_W-1:0] frm_data_i,
    input  logic              frm_end_i,
    input  logic              frm_crc_ok_i,
    input  logic              frm_ovr_i,
    input  logic              host_rel_i,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [WORD_W-1:0] mem_wdata_o,
    output logic [PKT_W-1:0]  rxq_head_o,
    output logic              rxq_empty_o,
    output logic              rx_int_o
);
    import rxbm_pkg::*;

    rxbm_state_e       state_q, state_d;
    logic [PKT_W-1:0]  cur_pkt_q;
    logic [PG_W-1:0]   first_pg_q, cur_pg_q;
    logic [IDX_W-1:0]  widx_q;
    logic [PG_W-1:0]   pg_tab_q [NUM_PKT][NUM_PAGE];
    logic [CNT_W-1:0]  pg_cnt_q [NUM_PKT];

    logic              pg_take, pkt_take, drop_free, q_push, q_pop;
    logic              pg_avail, pkt_avail;
    logic [PG_W-1:0]   pg_idx;
    logic [PKT_W-1:0]  pkt_idx;
    logic [NUM_PAGE-1:0] pg_rel, pg_free;
    logic [NUM_PKT-1:0]  pkt_rel, pkt_free;
    logic              need_pg;

    assign need_pg     = (widx_q[OFF_W-1:0] == '0);
    assign q_pop       = host_rel_i && !rxq_empty_o;
    assign rx_int_o    = !rxq_empty_o;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d     = state_q;
        pg_take     = 1'b0;
        pkt_take    = 1'b0;
        drop_free   = 1'b0;
        q_push      = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = '0;
        mem_wdata_o = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (rx_en_i && frm_start_i && pg_avail && pkt_avail) begin
                    pg_take  = 1'b1;
                    pkt_take = 1'b1;
                    state_d  = ST_RECV;
                end
            end
            ST_RECV: begin
                if (frm_end_i) begin
                    if (frm_crc_ok_i && !frm_ovr_i) state_d = ST_STAT;
                    else begin
                        drop_free = 1'b1;
                        state_d   = ST_IDLE;
                    end
                end else if (frm_vld_i) begin
                    if (need_pg && !pg_avail) begin
                        drop_free = 1'b1;
                        state_d   = ST_DROP;
                    end else begin
                        pg_take     = need_pg;
                        mem_we_o    = 1'b1;
                        mem_addr_o  = {need_pg ? pg_idx : cur_pg_q, widx_q[OFF_W-1:0]};
                        mem_wdata_o = frm_data_i;
                    end
                end
            end
            ST_DROP: begin
                if (frm_end_i) state_d = ST_IDLE;
            end
            ST_STAT: begin
                mem_we_o    = 1'b1;
                mem_addr_o  = {first_pg_q, OFF_W'(0)};
                mem_wdata_o = {1'b1, (WORD_W-1)'(pg_cnt_q[cur_pkt_q])};
                state_d     = ST_BCNT;
            end
            ST_BCNT: begin
                mem_we_o    = 1'b1;
                mem_addr_o  = {first_pg_q, OFF_W'(1)};
                mem_wdata_o = WORD_W'({widx_q, 1'b0});
                q_push      = 1'b1;
                state_d     = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // frame context and per-packet page lists
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_pkt_q  <= '0;
            first_pg_q <= '0;
            cur_pg_q   <= '0;
            widx_q     <= '0;
            for (int p = 0; p < NUM_PKT; p++) begin
                pg_cnt_q[p] <= '0;
                for (int i = 0; i < NUM_PAGE; i++) pg_tab_q[p][i] <= '0;
            end
        end else if (pkt_take) begin
            cur_pkt_q              <= pkt_idx;
            first_pg_q             <= pg_idx;
            cur_pg_q               <= pg_idx;
            widx_q                 <= IDX_W'(2);
            pg_tab_q[pkt_idx][0]   <= pg_idx;
            pg_cnt_q[pkt_idx]      <= CNT_W'(1);
        end else if (state_q == ST_RECV && mem_we_o) begin
            widx_q <= widx_q + 1'b1;
            if (pg_take) begin
                cur_pg_q <= pg_idx;
                pg_tab_q[cur_pkt_q][pg_cnt_q[cur_pkt_q][PG_W-1:0]] <= pg_idx;
                pg_cnt_q[cur_pkt_q] <= pg_cnt_q[cur_pkt_q] + 1'b1;
            end
        end
    end

    // release masks for a dropped frame and a host release
    always_comb begin
        pg_rel = '0;
        for (int i = 0; i < NUM_PAGE; i++) begin
            if (drop_free && CNT_W'(i) < pg_cnt_q[cur_pkt_q])
                pg_rel[pg_tab_q[cur_pkt_q][i]] = 1'b1;
            if (q_pop && CNT_W'(i) < pg_cnt_q[rxq_head_o])
                pg_rel[pg_tab_q[rxq_head_o][i]] = 1'b1;
        end
        pkt_rel = (drop_free ? (NUM_PKT'(1) << cur_pkt_q) : '0)
                | (q_pop ? (NUM_PKT'(1) << rxq_head_o) : '0);
    end

    rxbm_free_pool #(.N(NUM_PAGE)) u_pages (
        .clk(clk), .rst_n(rst_n), .take_i(pg_take), .rel_mask_i(pg_rel),
        .avail_o(pg_avail), .idx_o(pg_idx), .free_o(pg_free)
    );

    rxbm_free_pool #(.N(NUM_PKT)) u_nums (
        .clk(clk), .rst_n(rst_n), .take_i(pkt_take), .rel_mask_i(pkt_rel),
        .avail_o(pkt_avail), .idx_o(pkt_idx), .free_o(pkt_free)
    );

    rxbm_num_fifo #(.DEPTH(NUM_PKT), .W(PKT_W)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push_i(q_push), .data_i(cur_pkt_q),
        .pop_i(q_pop), .head_o(rxq_head_o), .empty_o(rxq_empty_o)
    );

    p_write_owned_page_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o && !pg_take) |-> !pg_free[mem_addr_o[ADDR_W-1:OFF_W]]);
    p_push_owned_num_r4: assert property (@(posedge clk) disable iff (!rst_n)
        q_push |-> !pkt_free[cur_pkt_q]);
    p_idle_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE || state_q == ST_DROP) |-> !mem_we_o);
    p_drop_leaves_queue_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_free && !q_pop) |=> $stable(rxq_empty_o));
endmodule

// File: tb/rx_pkt_buf_mgr_tb_top.sv
module rx_pkt_buf_mgr_tb_top;
    logic        clk = 0;
    logic        rst_n, rx_en_i, frm_start_i, frm_vld_i, frm_end_i;
    logic        frm_crc_ok_i, frm_ovr_i, host_rel_i;
    logic [15:0] frm_data_i;
    logic        mem_we_o, rxq_empty_o, rx_int_o;
    logic [10:0] mem_addr_o;
    logic [15:0] mem_wdata_o;
    logic [2:0]  rxq_head_o;

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit m_pg_free [16];
    bit m_pkt_free [8];
    int m_tab [8][16];
    int m_cnt [8];
    int q [$];

    // {payload words[15:3], crc ok[2], overrun[1], expect queued[0]}
    localparam logic [15:0] VEC [6] = '{
        {13'd4,   1'b1, 1'b0, 1'b1},
        {13'd0,   1'b1, 1'b0, 1'b1},
        {13'd5,   1'b0, 1'b0, 1'b0},
        {13'd3,   1'b1, 1'b1, 1'b0},
        {13'd300, 1'b1, 1'b0, 1'b1},
        {13'd1,   1'b1, 1'b0, 1'b1}
    };

    always #2 clk = ~clk;

    rx_pkt_buf_mgr dut_i (
        .clk(clk), .rst_n(rst_n), .rx_en_i(rx_en_i), .frm_start_i(frm_start_i),
        .frm_vld_i(frm_vld_i), .frm_data_i(frm_data_i), .frm_end_i(frm_end_i),
        .frm_crc_ok_i(frm_crc_ok_i), .frm_ovr_i(frm_ovr_i), .host_rel_i(host_rel_i),
        .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
        .rxq_head_o(rxq_head_o), .rxq_empty_o(rxq_empty_o), .rx_int_o(rx_int_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int low_pg();
        for (int i = 0; i < 16; i++) if (m_pg_free[i]) return i;
        return -1;
    endfunction

    function automatic int low_pkt();
        for (int i = 0; i < 8; i++) if (m_pkt_free[i]) return i;
        return -1;
    endfunction

    function automatic void free_pkt(input int p);
        for (int i = 0; i < m_cnt[p]; i++) m_pg_free[m_tab[p][i]] = 1;
        m_pkt_free[p] = 1;
    endfunction

    task automatic chk_queue(input string tag);
        chk(rxq_empty_o == (q.size() == 0), tag, int'(rxq_empty_o), int'(q.size() == 0));
        chk(rx_int_o == (q.size() != 0), "R8", int'(rx_int_o), int'(q.size() != 0));
        if (q.size() != 0) chk(int'(rxq_head_o) == q[0], tag, int'(rxq_head_o), q[0]);
    endtask

    task automatic send_frame(input int nw, input bit crc, input bit ovr, output bit kept);
        int p, pg, cur, widx, npg;
        bit held, started;
        string tag;
        kept = 0; held = 0; started = 0;
        @(negedge clk);
        frm_start_i = 1;
        p = low_pkt(); pg = low_pg();
        if (rx_en_i && p >= 0 && pg >= 0) begin
            held = 1; started = 1;
            m_pkt_free[p] = 0; m_pg_free[pg] = 0;
            m_tab[p][0] = pg; m_cnt[p] = 1; cur = pg;
        end
        tag = !rx_en_i ? "R10" : (started ? "R6" : "R7");
        @(posedge clk); @(negedge clk);
        frm_start_i = 0;
        widx = 2;
        for (int i = 0; i < nw; i++) begin
            frm_vld_i = 1; frm_data_i = 16'(i * 3 + nw);
            if (held && widx % 128 == 0) begin
                npg = low_pg();
                if (npg < 0) begin free_pkt(p); held = 0; end
                else begin
                    m_pg_free[npg] = 0; m_tab[p][m_cnt[p]] = npg; m_cnt[p]++; cur = npg;
                end
            end
            #1;
            if (held) begin
                chk(mem_we_o === 1'b1, (widx % 128 == 0) ? "R3" : "R2", int'(mem_we_o), 1);
                chk(int'(mem_addr_o) == cur * 128 + widx % 128,
                    (widx % 128 == 0) ? "R3" : "R2", int'(mem_addr_o), cur * 128 + widx % 128);
                chk(mem_wdata_o == frm_data_i, "R2", int'(mem_wdata_o), int'(frm_data_i));
            end else begin
                chk(mem_we_o === 1'b0, tag, int'(mem_we_o), 0);
            end
            widx++;
            @(posedge clk); @(negedge clk);
        end
        frm_vld_i = 0; frm_end_i = 1; frm_crc_ok_i = crc; frm_ovr_i = ovr;
        #1 chk(mem_we_o === 1'b0, "R4", int'(mem_we_o), 0);
        @(posedge clk); @(negedge clk);
        frm_end_i = 0; frm_crc_ok_i = 0; frm_ovr_i = 0;
        if (held && crc && !ovr) begin
            #1;
            chk(mem_we_o === 1'b1 && int'(mem_addr_o) == m_tab[p][0] * 128, "R4",
                int'(mem_addr_o), m_tab[p][0] * 128);
            chk(int'(mem_wdata_o) == (32768 + m_cnt[p]), "R4", int'(mem_wdata_o), 32768 + m_cnt[p]);
            @(posedge clk); @(negedge clk); #1;
            chk(mem_we_o === 1'b1 && int'(mem_addr_o) == m_tab[p][0] * 128 + 1, "R4",
                int'(mem_addr_o), m_tab[p][0] * 128 + 1);
            chk(int'(mem_wdata_o) == 2 * widx, "R4", int'(mem_wdata_o), 2 * widx);
            @(posedge clk); @(negedge clk);
            q.push_back(p); kept = 1;
        end else if (held) begin
            free_pkt(p);
            #1 chk(mem_we_o === 1'b0, "R5", int'(mem_we_o), 0);
        end
        #1 chk_queue(kept ? "R4" : "R5");
    endtask

    task automatic release_one(input string tag);
        @(negedge clk);
        host_rel_i = 1;
        @(posedge clk); @(negedge clk);
        host_rel_i = 0;
        if (q.size() != 0) begin free_pkt(q[0]); void'(q.pop_front()); end
        #1 chk_queue(tag);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual %0d expected below 150000", cyc);
                finish_run();
            end
        end
    end

    initial begin
        bit kept;
        int h;
        rst_n = 0; rx_en_i = 1; frm_start_i = 0; frm_vld_i = 0; frm_data_i = 0;
        frm_end_i = 0; frm_crc_ok_i = 0; frm_ovr_i = 0; host_rel_i = 0;
        for (int i = 0; i < 16; i++) m_pg_free[i] = 1;
        for (int i = 0; i < 8; i++) begin m_pkt_free[i] = 1; m_cnt[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;
        #1;
        // R1 reset state
        chk(rxq_empty_o === 1'b1, "R1", int'(rxq_empty_o), 1);
        chk(rx_int_o === 1'b0, "R1", int'(rx_int_o), 0);
        chk(mem_we_o === 1'b0, "R1", int'(mem_we_o), 0);

        // vector table: R2 R3 R4 R5
        for (int v = 0; v < 6; v++) begin
            send_frame(int'(VEC[v][15:3]), VEC[v][2], VEC[v][1], kept);
            chk(kept == VEC[v][0], VEC[v][0] ? "R4" : "R5", int'(kept), int'(VEC[v][0]));
        end
        // R11 ordering: frames queued as 0,1,2,3
        for (int i = 0; i < 4; i++) begin
            chk(int'(rxq_head_o) == i, "R11", int'(rxq_head_o), i);
            release_one("R9");
        end
        // R9 empty release ignored, then fresh frame reuses number 0 / page 0
        release_one("R9");
        release_one("R9");
        send_frame(2, 1, 0, kept);
        chk(kept && int'(rxq_head_o) == 0, "R9", int'(rxq_head_o), 0);
        release_one("R9");
        // R10 receive disabled
        rx_en_i = 0;
        send_frame(3, 1, 0, kept);
        chk(!kept && rxq_empty_o, "R10", int'(kept), 0);
        rx_en_i = 1;
        // R6 / R7 page exhaustion
        send_frame(2000, 1, 0, kept);
        chk(kept, "R4", int'(kept), 1);
        send_frame(2, 1, 0, kept);
        chk(!kept, "R7", int'(kept), 0);
        release_one("R9");
        send_frame(2100, 1, 0, kept);
        chk(!kept, "R6", int'(kept), 0);
        send_frame(1, 1, 0, kept);
        chk(kept && low_pg() == 1, "R6", low_pg(), 1);
        release_one("R9");
        // R7 packet number exhaustion, then R11 drain order
        for (int i = 0; i < 8; i++) send_frame(1, 1, 0, kept);
        send_frame(1, 1, 0, kept);
        chk(!kept, "R7", int'(kept), 0);
        for (int i = 0; i < 8; i++) begin
            h = q[0];
            chk(int'(rxq_head_o) == h, "R11", int'(rxq_head_o), h);
            release_one("R9");
        end
        chk(rxq_empty_o === 1'b1 && rx_int_o === 1'b0, "R8", int'(rx_int_o), 0);
        finish_run();
    end
endmodule